// File: doc/BRIEF.md
# Internal Periodic Update Strobe Generator

This block produces the register-update event from inside the chip, so that no outside controller has to strobe the update line. While it is enabled, it takes over the shared update pin as an output. A prescaler divides the system clock by 1, 2, 4 or 8, selected by a 2-bit code. Its ticks step a down-counter that is loaded from a programmable rate word. Each time the counter runs out, the block raises a one-cycle internal update event. It also drives a fixed-width, active-high notification pulse on the pin, which tells the external controller that an update took place.

A control FSM orders the work in three named states. ST_IDLE is the disabled state: the pin is released and the counter keeps following the rate word. ST_LOAD takes one cycle after enable is seen: it captures the divide code and decides whether the rate word selects the static level. ST_COUNT does the prescaled counting and reloads on each expiry. Its transitions are as follows. IDLE→LOAD happens when enable is high. LOAD→COUNT happens when enable stays high. Any state goes →IDLE when enable is low.

A second FSM in the pulse shaper has two states. PS_LOW→PS_HIGH happens on an update event. PS_HIGH→PS_HIGH happens as it counts down, and restarts on a new event. PS_HIGH→PS_LOW happens when the width has been served or the block is disabled. The repetition rate is f_clk / (2^A × B), where A is the divide code and B is the rate word. A rate word of 3 or less turns the notification into a constant high level.

Top module: `upd_strobe_gen`

## Requirements
- R1: While `enable` is low, `upd_pin_oe`, `upd_pin_o` and `upd_event` are all low, and no update event is produced.
- R2: If `enable` is first sampled high at clock edge k, `upd_pin_oe` is high from edge k on. The first `upd_event` rises at edge k+1+N, where N = 2^A × max(B,1).
- R3: The divide code `rate_sel` maps 0→÷1, 1→÷2, 2→÷4 and 3→÷8. While the block stays enabled, successive update events are exactly N = 2^A × max(B,1) clock cycles apart.
- R4: `upd_event` is high for exactly one clock cycle per expiry whenever N > 1.
- R5: `upd_pin_o` rises in the same cycle as `upd_event`. It stays high for exactly PULSE_LEN (12) cycles when N > 12.
- R6: An event that arrives while the pulse is still high restarts the 12-cycle window. A period of 12 cycles or less therefore keeps `upd_pin_o` continuously high.
- R7: A rate word of 3 or less (STATIC_MAX) holds `upd_pin_o` at a static 1 from the second enabled cycle onward. Events still occur every N cycles, and a rate word of 0 counts as 1.
- R8: A change of `rate_sel` or `rate_word` during a count has no effect until the next reload. The period already under way keeps its old length.
- R9: A low `enable` sampled at an edge returns the block to ST_IDLE at that edge. From then on `upd_pin_oe`, `upd_pin_o` and `upd_event` are low, and a pulse under way is cut off.
- R10: While `rst_n` is low, all outputs are low and the control FSM is in ST_IDLE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Turns internal update generation on |
| rate_sel | input | 2 | Prescale code A (divide by 2^A) |
| rate_word | input | 32 | Counter range B |
| upd_event | output | 1 | One-cycle internal update event |
| upd_pin_o | output | 1 | Notification level driven onto the update pin |
| upd_pin_oe | output | 1 | Output enable for the update pin |

## Verification
The bench builds the block with its default parameters: a 32-bit counter, a 2-bit divide code, a 12-cycle pulse and a static threshold of 3. Because the rate word is a run-time input, the bench uses small rate words and can reach every divide code in periods of 4 to 40 cycles. This covers periods both above and below the pulse width, so both the separate pulse and the retriggered continuous level are observed. The static range is reached with words of 3 and 0, and the deferred reload is reached by changing the word in the middle of a count.

// File: rtl/upd_strobe_pkg.sv
package upd_strobe_pkg;

    // Control sequencer states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_COUNT = 2'd2
    } ctl_state_t;

    // Notification pulse states
    typedef enum logic {
        PS_LOW  = 1'b0,
        PS_HIGH = 1'b1
    } pulse_state_t;

endpackage

// File: rtl/usg_prescaler.sv
module usg_prescaler #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    // Largest divide is 2^(2^SEL_W - 1); phase counter width matches it.
    localparam int PRE_W = (1 << SEL_W) - 1;

    logic [PRE_W-1:0] phase_q;
    logic [PRE_W-1:0] mask;

    always_comb begin
        mask = '0;
        for (int i = 0; i < PRE_W; i++) begin
            if (i < int'(sel)) mask[i] = 1'b1;
        end
    end

    assign tick = run && (phase_q == mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (clr || tick) begin
            phase_q <= '0;
        end else if (run) begin
            phase_q <= phase_q + 1'b1;
        end
    end

endmodule

// File: rtl/usg_rate_counter.sv
module usg_rate_counter #(
    parameter int              CNT_W      = 32,
    parameter logic [CNT_W-1:0] RESET_RATE = 32'h0000_FFFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             tick,
    input  logic [CNT_W-1:0] rate,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] rate_eff;

    // A zero range is served as a single tick.
    assign rate_eff = (rate == '0) ? CNT_W'(1) : rate;
    assign expire   = tick && (cnt_q == CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= RESET_RATE;
        end else if (load || expire) begin
            cnt_q <= rate_eff;
        end else if (tick) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/usg_pulse_shaper.sv
module usg_pulse_shaper
    import upd_strobe_pkg::*;
#(
    parameter int PULSE_LEN = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic fire,
    output logic active
);
    localparam int LEN_W = $clog2(PULSE_LEN + 1);

    pulse_state_t ps_q, ps_d;
    logic [LEN_W-1:0] rem_q, rem_d;

    always_comb begin
        ps_d  = ps_q;
        rem_d = rem_q;
        if (clr) begin
            ps_d  = PS_LOW;
            rem_d = '0;
        end else if (fire) begin
            ps_d  = PS_HIGH;
            rem_d = LEN_W'(PULSE_LEN - 1);
        end else begin
            unique case (ps_q)
                PS_LOW: begin
                    rem_d = '0;
                end
                PS_HIGH: begin
                    if (rem_q == '0) ps_d = PS_LOW;
                    else             rem_d = rem_q - 1'b1;
                end
                default: ps_d = PS_LOW;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ps_q  <= PS_LOW;
            rem_q <= '0;
        end else begin
            ps_q  <= ps_d;
            rem_q <= rem_d;
        end
    end

    assign active = (ps_q == PS_HIGH);

endmodule

// File: rtl/upd_strobe_gen.sv
module upd_strobe_gen
    import upd_strobe_pkg::*;
#(
    parameter int               CNT_W      = 32,
    parameter int               SEL_W      = 2,
    parameter int               PULSE_LEN  = 12,
    parameter int               STATIC_MAX = 3,
    parameter logic [SEL_W-1:0] RESET_SEL  = '0,
    parameter logic [CNT_W-1:0] RESET_RATE = 32'h0000_FFFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [SEL_W-1:0] rate_sel,
    input  logic [CNT_W-1:0] rate_word,
    output logic             upd_event,
    output logic             upd_pin_o,
    output logic             upd_pin_oe
);
    ctl_state_t state_q, state_d;

    logic [SEL_W-1:0] sel_q;
    logic             static_q;
    logic             event_q;
    logic             tick;
    logic             expire;
    logic             fire;
    logic             pulse_on;
    logic             capture;

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = enable ? ST_LOAD  : ST_IDLE;
            ST_LOAD:  state_d = enable ? ST_COUNT : ST_IDLE;
            ST_COUNT: state_d = enable ? ST_COUNT : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Capture of divide code and static flag: on entry and on every reload.
    assign capture = (state_q == ST_LOAD) || ((state_q == ST_COUNT) && expire);
    assign fire    = (state_q == ST_COUNT) && enable && expire;

    // ---------------- outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q    <= RESET_SEL;
            static_q <= 1'b0;
            event_q  <= 1'b0;
        end else begin
            event_q <= fire;
            if (state_q == ST_IDLE) begin
                static_q <= 1'b0;
            end else if (capture) begin
                sel_q    <= rate_sel;
                static_q <= (rate_word <= CNT_W'(STATIC_MAX));
            end
        end
    end

    usg_prescaler #(
        .SEL_W (SEL_W)
    ) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_q != ST_COUNT),
        .run   (state_q == ST_COUNT),
        .sel   (sel_q),
        .tick  (tick)
    );

    usg_rate_counter #(
        .CNT_W      (CNT_W),
        .RESET_RATE (RESET_RATE)
    ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (state_q != ST_COUNT),
        .tick   (tick),
        .rate   (rate_word),
        .expire (expire)
    );

    usg_pulse_shaper #(
        .PULSE_LEN (PULSE_LEN)
    ) u_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (state_d == ST_IDLE),
        .fire   (fire),
        .active (pulse_on)
    );

    assign upd_event  = event_q;
    assign upd_pin_oe = (state_q != ST_IDLE);
    assign upd_pin_o  = upd_pin_oe && (static_q || pulse_on);

endmodule

// File: rtl/upd_strobe_chk.sv
module upd_strobe_chk #(
    parameter int PULSE_LEN = 12
) (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic upd_event,
    input logic upd_pin_o,
    input logic upd_pin_oe
);
    logic [15:0] hi_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 hi_run_q <= '0;
        else if (!upd_pin_o)        hi_run_q <= '0;
        else if (hi_run_q != '1)    hi_run_q <= hi_run_q + 1'b1;
    end

    // R1
    no_event_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_pin_oe |-> !upd_event);

    // R2
    no_event_on_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(upd_pin_oe) |-> !upd_event);

    // R5
    pin_with_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_event |-> upd_pin_o);

    // R5
    min_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(upd_pin_o) && upd_pin_oe && $past(upd_pin_oe)) |-> (hi_run_q >= 16'(PULSE_LEN)));

    // R9
    event_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_event |-> $past(enable));

endmodule

bind upd_strobe_gen upd_strobe_chk #(.PULSE_LEN(PULSE_LEN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .upd_event  (upd_event),
    .upd_pin_o  (upd_pin_o),
    .upd_pin_oe (upd_pin_oe)
);

// File: tb/upd_strobe_gen_tb_top.sv
`timescale 1ns/1ps
module upd_strobe_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [1:0]  rate_sel = 2'd0;
    logic [31:0] rate_word = 32'd0;
    logic        upd_event;
    logic        upd_pin_o;
    logic        upd_pin_oe;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    upd_strobe_gen dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .rate_sel   (rate_sel),
        .rate_word  (rate_word),
        .upd_event  (upd_event),
        .upd_pin_o  (upd_pin_o),
        .upd_pin_oe (upd_pin_oe)
    );

    // stimulus and expectations: divide code, rate word, period, high cycles per period
    localparam int NV = 8;
    localparam int V_SEL [NV] = '{0, 1, 2, 3, 0, 1, 2, 0};
    localparam int V_RATE[NV] = '{20, 10, 7, 5, 4, 3, 0, 13};
    localparam int V_PER [NV] = '{20, 20, 28, 40, 4, 6, 4, 13};
    localparam int V_HI  [NV] = '{12, 12, 12, 12, 4, 6, 4, 12};

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wait_evt(input int limit, output int n);
        n = 0;
        do begin
            step();
            n++;
        end while (!upd_event && n < limit);
    endtask

    task automatic go_idle();
        enable = 1'b0;
        step();
        step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int n;
        int m;
        int hi;
        int bad;

        // R10: reset state
        repeat (3) @(negedge clk);
        chk(!upd_pin_oe && !upd_pin_o && !upd_event, "R10", {upd_pin_oe, upd_pin_o, upd_event}, 0);
        rst_n = 1'b1;

        // R1: idle with enable low
        bad = 0;
        for (int i = 0; i < 50; i++) begin
            step();
            if (upd_event || upd_pin_oe || upd_pin_o) bad++;
        end
        chk(bad == 0, "R1 idle", bad, 0);

        // table walk: R2 latency, R3 period, R4 single cycle, R5/R6/R7 high time
        for (int v = 0; v < NV; v++) begin
            go_idle();
            rate_sel  = 2'(V_SEL[v]);
            rate_word = 32'(V_RATE[v]);
            enable    = 1'b1;
            step();
            chk(upd_pin_oe == 1'b1, "R2 oe", upd_pin_oe, 1);
            wait_evt(400, n);
            chk(n + 1 == V_PER[v] + 2, "R2 first event", n + 1, V_PER[v] + 2);
            hi = upd_pin_o ? 1 : 0;
            m  = 0;
            do begin
                step();
                m++;
                if (m == 1) chk(!upd_event, "R4 single cycle", upd_event, 0);
                if (!upd_event && upd_pin_o) hi++;
            end while (!upd_event && m < 400);
            chk(m == V_PER[v], "R3 period", m, V_PER[v]);
            chk(hi == V_HI[v], "R5/R6/R7 high cycles", hi, V_HI[v]);
        end

        // R7: static level from the second enabled cycle
        go_idle();
        rate_sel  = 2'd0;
        rate_word = 32'd2;
        enable    = 1'b1;
        step();
        chk(upd_pin_oe && !upd_pin_o, "R7 load cycle", upd_pin_o, 0);
        bad = 0;
        for (int i = 0; i < 30; i++) begin
            step();
            if (!upd_pin_o) bad++;
        end
        chk(bad == 0, "R7 static high", bad, 0);

        // R8: rate change mid-count waits for reload
        go_idle();
        rate_sel  = 2'd0;
        rate_word = 32'd30;
        enable    = 1'b1;
        wait_evt(400, n);
        step();
        rate_word = 32'd10;
        m = 1;
        while (!upd_event && m < 400) begin
            step();
            m++;
        end
        chk(m == 30, "R8 old period kept", m, 30);
        wait_evt(400, n);
        chk(n == 10, "R8 new period", n, 10);

        // R9: disable during a pulse
        step();
        step();
        chk(upd_pin_o == 1'b1, "R9 pulse running", upd_pin_o, 1);
        enable = 1'b0;
        step();
        chk(!upd_pin_oe && !upd_pin_o && !upd_event, "R9 disable", {upd_pin_oe, upd_pin_o, upd_event}, 0);
        bad = 0;
        for (int i = 0; i < 40; i++) begin
            step();
            if (upd_event || upd_pin_o || upd_pin_oe) bad++;
        end
        chk(bad == 0, "R1 after disable", bad, 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule